// File: doc/BRIEF.md
# Bus Cycle Sequencer for an 8-bit Processor Core

This block produces, one clock per bus cycle, the exact series of memory accesses that a small 8-bit processor performs for three instruction classes: a load through an absolute address plus an index register, an increment applied in place to an absolute address, and a conditional relative branch. Each active cycle drives an address, a read/write strobe and, for writes, the write data. Read data comes back within the same cycle.

The series includes the accesses that do no useful work but still reach memory-mapped peripherals. A peripheral that clears a status bit when read will see these accesses. They are: the read from the uncorrected address when an indexed low-byte sum carries, the extra write-back or extra read inside the in-place increment, and the read of the byte after a branch offset. A mode input selects between the older ordering of the in-place increment and the newer one.

The core around the block latches an instruction by pulsing `start` with a class code and its operands while the block is idle. It then serves the bus cycles and takes `next_pc`, `result` and the zero and negative flags when `done` marks the last cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and after it is released, `cyc_valid` and `done` are 0, `result` is 0x00, `flag_z` is 1 and `flag_n` is 0.
- R2: An accepted `start` latches all operand inputs. The first bus cycle comes on the next clock and is a read at `pc`, followed by a read at `pc+1`. The load and increment classes then add a read at `pc+2`. Every bus cycle lasts one clock with `cyc_valid` high, and later changes on operand inputs have no effect.
- R3: Load (class 0) with no carry out of `base[7:0] + index`: one read at `base + index`, which is the `done` cycle. `result` takes the data read there.
- R4: Load with a carry out of the low-byte sum: first a read at `{base[15:8], (base[7:0]+index) mod 256}`, then the `done` read at `base + index` (for example base 0xFEE8 with index 0x80 reads 0xFE68, then 0xFF68).
- R5: Increment (class 1) with `rmw_late` = 0: read at `base`, write of the unchanged value to `base`, then the `done` write of value+1 to `base`.
- R6: Increment with `rmw_late` = 1: read at `base`, a second read at `base`, then a single `done` write of value+1 to `base`.
- R7: The increment wraps 0xFF to 0x00. From the cycle after `done`, `result` holds the loaded or written value, `flag_z` = (`result` == 0) and `flag_n` = `result[7]`.
- R8: Branch (class 2) with `br_cond` = 0: the read at `pc+1` is the `done` cycle and `next_pc` = `pc+2`.
- R9: Branch with `br_cond` = 1: a read at `pc+2` follows. When the target `pc+2+sext(br_off)` (a two's-complement offset) lies on the same 256-byte page as `pc+2`, that read is the `done` cycle and `next_pc` is the target.
- R10: A taken branch whose target lies on a different page than `pc+2` adds a `done` read at `{pc2[15:8], target[7:0]}`.
- R11: `done` is high in exactly the last cycle of an instruction, and `cyc_valid` is low in the cycle after it. `start` pulsed while a sequence runs is ignored. For load and increment, `next_pc` = `pc+3` in the `done` cycle.
- R12: Class code 3 is reserved: a `start` with it is ignored and no bus cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an instruction; taken only when idle |
| op_class | input | 2 | 0 load indexed, 1 in-place increment, 2 branch, 3 reserved |
| rmw_late | input | 1 | 0 older increment ordering, 1 newer ordering |
| pc | input | 16 | Address of the opcode byte |
| base | input | 16 | Absolute operand address |
| index | input | 8 | Index register value |
| br_off | input | 8 | Branch offset, two's complement |
| br_cond | input | 1 | Branch condition is true |
| rdata | input | 8 | Read data for the current cycle |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 read, 0 write |
| wdata | output | 8 | Write data (0 on reads) |
| cyc_valid | output | 1 | A bus cycle is in progress |
| done | output | 1 | Last cycle of the instruction |
| next_pc | output | 16 | Address of the following opcode, valid with `done` |
| result | output | 8 | Last loaded or incremented value |
| flag_z | output | 1 | `result` is zero |
| flag_n | output | 1 | Bit 7 of `result` |

## Verification
The assertions assume that `rdata` is settled within the same cycle as the address and that `start` reaches the block synchronously. They make no assumption about the operand inputs after `start`. The stimulus holds the increment mode fixed for the duration of each instruction. It scrambles the other operand inputs right after each start and pulses `start` again in the middle of a sequence, so the latching and the busy rejection are observed rather than assumed. The bench memory answers every address, so the dummy accesses always get defined read data, and a few chosen cells hold 0xFF and 0x7F to reach the wrap and sign cases.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [1:0] {
    CLS_LOAD   = 2'd0,
    CLS_RMW    = 2'd1,
    CLS_BRANCH = 2'd2,
    CLS_NONE   = 2'd3
  } cls_e;

  typedef enum logic [3:0] {
    PH_IDLE      = 4'd0,
    PH_OPC       = 4'd1,
    PH_OP1       = 4'd2,
    PH_OP2       = 4'd3,
    PH_IDX_DUMMY = 4'd4,
    PH_IDX_FINAL = 4'd5,
    PH_RMW_RD    = 4'd6,
    PH_RMW_MID   = 4'd7,
    PH_RMW_WR    = 4'd8,
    PH_BR_NEXT   = 4'd9,
    PH_BR_FIX    = 4'd10
  } phase_e;

endpackage

// File: rtl/bsq_addr_calc.sv
module bsq_addr_calc #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] index,
  input  logic [DW-1:0] off,
  output logic [AW-1:0] pc_p1,
  output logic [AW-1:0] pc_p2,
  output logic [AW-1:0] pc_p3,
  output logic [AW-1:0] idx_wrap,
  output logic [AW-1:0] idx_eff,
  output logic          idx_carry,
  output logic [AW-1:0] br_tgt,
  output logic [AW-1:0] br_fix,
  output logic          br_cross
);
  localparam int PW = AW - DW;
  localparam logic [AW-1:0] ONE   = AW'(1);
  localparam logic [AW-1:0] TWO   = AW'(2);
  localparam logic [AW-1:0] THREE = AW'(3);

  logic [DW:0] lo_sum;

  always_comb begin
    pc_p1     = pc + ONE;
    pc_p2     = pc + TWO;
    pc_p3     = pc + THREE;
    lo_sum    = {1'b0, base[DW-1:0]} + {1'b0, index};
    idx_carry = lo_sum[DW];
    idx_wrap  = {base[AW-1:DW], lo_sum[DW-1:0]};
    idx_eff   = base + {{PW{1'b0}}, index};
    br_tgt    = pc_p2 + {{PW{off[DW-1]}}, off};
    br_fix    = {pc_p2[AW-1:DW], br_tgt[DW-1:0]};
    br_cross  = (br_tgt[AW-1:DW] != pc_p2[AW-1:DW]);
  end
endmodule

// File: rtl/bsq_seq_ctrl.sv
module bsq_seq_ctrl
  import bsq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_class,
  input  logic          rmw_late_in,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] base_in,
  input  logic [DW-1:0] idx_in,
  input  logic [DW-1:0] off_in,
  input  logic          cond_in,
  input  logic          idx_carry,
  input  logic          br_cross,
  output phase_e        phase,
  output cls_e          cls,
  output logic          rmw_late,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] base_q,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] off_q,
  output logic          cond_q,
  output logic          done
);
  phase_e phase_q, phase_d;
  logic   accept;

  // start is taken only when idle and with a defined class code
  assign accept = start && (phase_q == PH_IDLE) && (cls_e'(op_class) != CLS_NONE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:      if (accept) phase_d = PH_OPC;
      PH_OPC:       phase_d = PH_OP1;
      PH_OP1: begin
        if (cls == CLS_BRANCH) phase_d = cond_q ? PH_BR_NEXT : PH_IDLE;
        else                   phase_d = PH_OP2;
      end
      PH_OP2: begin
        if (cls == CLS_LOAD) phase_d = idx_carry ? PH_IDX_DUMMY : PH_IDX_FINAL;
        else                 phase_d = PH_RMW_RD;
      end
      PH_IDX_DUMMY: phase_d = PH_IDX_FINAL;
      PH_IDX_FINAL: phase_d = PH_IDLE;
      PH_RMW_RD:    phase_d = PH_RMW_MID;
      PH_RMW_MID:   phase_d = PH_RMW_WR;
      PH_RMW_WR:    phase_d = PH_IDLE;
      PH_BR_NEXT:   phase_d = br_cross ? PH_BR_FIX : PH_IDLE;
      PH_BR_FIX:    phase_d = PH_IDLE;
      default:      phase_d = PH_IDLE;
    endcase
  end

  assign done  = (phase_q != PH_IDLE) && (phase_d == PH_IDLE);
  assign phase = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls      <= CLS_NONE;
      rmw_late <= 1'b0;
      pc_q     <= '0;
      base_q   <= '0;
      idx_q    <= '0;
      off_q    <= '0;
      cond_q   <= 1'b0;
    end else if (accept) begin
      cls      <= cls_e'(op_class);
      rmw_late <= rmw_late_in;
      pc_q     <= pc_in;
      base_q   <= base_in;
      idx_q    <= idx_in;
      off_q    <= off_in;
      cond_q   <= cond_in;
    end
  end
endmodule

// File: rtl/bsq_data_unit.sv
module bsq_data_unit
  import bsq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] tmp,
  output logic [DW-1:0] inc_val,
  output logic [DW-1:0] result,
  output logic          flag_z,
  output logic          flag_n
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          tmp_en, res_en;
  logic [DW-1:0] res_d;

  always_comb begin
    inc_val = tmp + ONE;  // wraps at the top of the range
    tmp_en  = (phase == PH_RMW_RD);
    res_en  = (phase == PH_IDX_FINAL) || (phase == PH_RMW_WR);
    res_d   = (phase == PH_RMW_WR) ? inc_val : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmp <= '0;
    else if (tmp_en) tmp <= rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result <= '0;
    else if (res_en) result <= res_d;
  end

  assign flag_z = (result == '0);
  assign flag_n = result[DW-1];
endmodule

// File: rtl/bsq_bus_mux.sv
module bsq_bus_mux
  import bsq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  phase_e        phase,
  input  logic          rmw_late,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] pc_p1,
  input  logic [AW-1:0] pc_p2,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx_wrap,
  input  logic [AW-1:0] idx_eff,
  input  logic [AW-1:0] br_fix,
  input  logic [DW-1:0] tmp,
  input  logic [DW-1:0] inc_val,
  output logic [AW-1:0] addr,
  output logic          rw,
  output logic [DW-1:0] wdata,
  output logic          cyc_valid
);
  always_comb begin
    addr      = '0;
    rw        = 1'b1;
    wdata     = '0;
    cyc_valid = 1'b1;
    case (phase)
      PH_OPC:       addr = pc;
      PH_OP1:       addr = pc_p1;
      PH_OP2:       addr = pc_p2;
      PH_IDX_DUMMY: addr = idx_wrap;
      PH_IDX_FINAL: addr = idx_eff;
      PH_RMW_RD:    addr = base;
      PH_RMW_MID: begin
        addr = base;
        if (!rmw_late) begin
          rw    = 1'b0;
          wdata = tmp;
        end
      end
      PH_RMW_WR: begin
        addr  = base;
        rw    = 1'b0;
        wdata = inc_val;
      end
      PH_BR_NEXT:   addr = pc_p2;
      PH_BR_FIX:    addr = br_fix;
      default:      cyc_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bsq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_class,
  input  logic          rmw_late,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] index,
  input  logic [DW-1:0] br_off,
  input  logic          br_cond,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic          rw,
  output logic [DW-1:0] wdata,
  output logic          cyc_valid,
  output logic          done,
  output logic [AW-1:0] next_pc,
  output logic [DW-1:0] result,
  output logic          flag_z,
  output logic          flag_n
);
  logic   rst_s0, rst_s1;
  phase_e phase;
  cls_e   cls;
  logic   late_q, cond_q, idx_carry, br_cross;
  logic [AW-1:0] pc_q, base_q, pc_p1, pc_p2, pc_p3, idx_wrap, idx_eff, br_tgt, br_fix;
  logic [DW-1:0] idx_q, off_q, tmp, inc_val;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  bsq_seq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_s1), .start(start), .op_class(op_class),
    .rmw_late_in(rmw_late), .pc_in(pc), .base_in(base), .idx_in(index),
    .off_in(br_off), .cond_in(br_cond), .idx_carry(idx_carry), .br_cross(br_cross),
    .phase(phase), .cls(cls), .rmw_late(late_q), .pc_q(pc_q), .base_q(base_q),
    .idx_q(idx_q), .off_q(off_q), .cond_q(cond_q), .done(done)
  );

  bsq_addr_calc #(.AW(AW), .DW(DW)) u_calc (
    .pc(pc_q), .base(base_q), .index(idx_q), .off(off_q),
    .pc_p1(pc_p1), .pc_p2(pc_p2), .pc_p3(pc_p3), .idx_wrap(idx_wrap),
    .idx_eff(idx_eff), .idx_carry(idx_carry), .br_tgt(br_tgt),
    .br_fix(br_fix), .br_cross(br_cross)
  );

  bsq_data_unit #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_s1), .phase(phase), .rdata(rdata),
    .tmp(tmp), .inc_val(inc_val), .result(result),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  bsq_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .phase(phase), .rmw_late(late_q), .pc(pc_q), .pc_p1(pc_p1), .pc_p2(pc_p2),
    .base(base_q), .idx_wrap(idx_wrap), .idx_eff(idx_eff), .br_fix(br_fix),
    .tmp(tmp), .inc_val(inc_val), .addr(addr), .rw(rw), .wdata(wdata),
    .cyc_valid(cyc_valid)
  );

  always_comb begin
    if (cls == CLS_BRANCH) next_pc = cond_q ? br_tgt : pc_p2;
    else                   next_pc = pc_p3;
  end
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] addr,
  input logic          rw,
  input logic [DW-1:0] wdata,
  input logic          cyc_valid,
  input logic          done,
  input logic          flag_z,
  input logic          flag_n
);
  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !rw) |-> ($past(cyc_valid) && addr == $past(addr))); // R5

  AST_FIRST_WRITE_THEN_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !rw && !done) |=> (cyc_valid && !rw && wdata == $past(wdata) + 1'b1)); // R5

  AST_SEQ_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_valid) |-> ($past(start) && rw)); // R2

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cyc_valid); // R11

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !done) |=> cyc_valid); // R11

  AST_FLAGS_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rw) |=> (flag_z == ($past(wdata) == '0) && flag_n == $past(wdata[DW-1]))); // R7
endmodule

bind bus_cycle_seq bsq_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .rw(rw),
  .wdata(wdata), .cyc_valid(cyc_valid), .done(done),
  .flag_z(flag_z), .flag_n(flag_n)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  logic        clk, rst_n, start, rmw_late, br_cond;
  logic [1:0]  op_class;
  logic [15:0] pc, base, addr, next_pc;
  logic [7:0]  index, br_off, rdata, wdata, result;
  logic        rw, cyc_valid, done, flag_z, flag_n;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] a;
    logic        rd;
    logic [7:0]  wd;
    logic        dn;
    logic [15:0] npc;
    int          rq;
  } item_t;
  item_t exp_q[$];

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
    .rmw_late(rmw_late), .pc(pc), .base(base), .index(index),
    .br_off(br_off), .br_cond(br_cond), .rdata(rdata), .addr(addr),
    .rw(rw), .wdata(wdata), .cyc_valid(cyc_valid), .done(done),
    .next_pc(next_pc), .result(result), .flag_z(flag_z), .flag_n(flag_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] mem_f(logic [15:0] a);
    if (a == 16'h2000) return 8'hFF;
    if (a == 16'h2100) return 8'h7F;
    return (a[7:0] ^ a[15:8]) + 8'h11;
  endfunction
  assign rdata = mem_f(addr);

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic rd, input logic [7:0] wd,
                      input logic dn, input logic [15:0] npc, input int rq);
    item_t it;
    it.a = a; it.rd = rd; it.wd = wd; it.dn = dn; it.npc = npc; it.rq = rq;
    exp_q.push_back(it);
  endtask

  // monitor: pops one expected bus cycle per active cycle
  always @(negedge clk) begin
    if (rst_n && cyc_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, 11, "unexpected bus cycle at addr", {16'h0, addr}, 32'h0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(addr == it.a, it.rq, "addr", {16'h0, addr}, {16'h0, it.a});
        chk(rw == it.rd, it.rq, "rw", {31'h0, rw}, {31'h0, it.rd});
        if (!it.rd) chk(wdata == it.wd, it.rq, "wdata", {24'h0, wdata}, {24'h0, it.wd});
        chk(done == it.dn, 11, "done", {31'h0, done}, {31'h0, it.dn});
        if (it.dn) chk(next_pc == it.npc, it.rq, "next_pc", {16'h0, next_pc}, {16'h0, it.npc});
      end
    end
  end

  // driver: computes the expected cycles (R2..R10), starts, scrambles operands (R2)
  task automatic run(input logic [1:0] cls, input logic late, input logic [15:0] p,
                     input logic [15:0] b, input logic [7:0] ix, input logic [7:0] of,
                     input logic cnd, input bit poke);
    logic [8:0]  lo;
    logic [15:0] p2, tgt, fix;
    logic [7:0]  v, res;
    bit          has_res;
    p2 = p + 16'd2;
    has_res = 0;
    res = 8'h00;
    push(p, 1, 0, 0, 0, 2);
    push(p + 16'd1, 1, 0, (cls == 2'd2) && !cnd, p2, (cls == 2'd2) ? 8 : 2);
    if (cls == 2'd0) begin
      push(p2, 1, 0, 0, 0, 2);
      lo = {1'b0, b[7:0]} + {1'b0, ix};
      if (lo[8]) push({b[15:8], lo[7:0]}, 1, 0, 0, 0, 4);   // R4 dummy read
      push(b + {8'h0, ix}, 1, 0, 1, p + 16'd3, lo[8] ? 4 : 3); // R3
      res = mem_f(b + {8'h0, ix});
      has_res = 1;
    end else if (cls == 2'd1) begin
      push(p2, 1, 0, 0, 0, 2);
      v = mem_f(b);
      push(b, 1, 0, 0, 0, late ? 6 : 5);
      if (late) push(b, 1, 0, 0, 0, 6);      // R6 second read
      else      push(b, 0, v, 0, 0, 5);      // R5 unchanged write-back
      push(b, 0, v + 8'd1, 1, p + 16'd3, 7); // R7 wrap of the increment
      res = v + 8'd1;
      has_res = 1;
    end else if (cnd) begin
      tgt = p2 + {{8{of[7]}}, of};
      fix = {p2[15:8], tgt[7:0]};
      push(p2, 1, 0, tgt[15:8] == p2[15:8], tgt, 9);
      if (tgt[15:8] != p2[15:8]) push(fix, 1, 0, 1, tgt, 10);
    end
    @(negedge clk);
    op_class = cls; rmw_late = late; pc = p; base = b; index = ix;
    br_off = of; br_cond = cnd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pc = ~p; base = ~b; index = ~ix; br_off = ~of; br_cond = ~cnd;
    if (poke) begin
      @(negedge clk);
      op_class = 2'd0; start = 1'b1;  // R11: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(cyc_valid == 1'b0, 11, "cyc_valid after done", {31'h0, cyc_valid}, 32'h0);
    if (has_res) begin
      chk(result == res, 7, "result", {24'h0, result}, {24'h0, res});
      chk(flag_z == (res == 8'h00), 7, "flag_z", {31'h0, flag_z}, {31'h0, res == 8'h00});
      chk(flag_n == res[7], 7, "flag_n", {31'h0, flag_n}, {31'h0, res[7]});
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_class = 2'd0; rmw_late = 1'b0;
    pc = '0; base = '0; index = '0; br_off = '0; br_cond = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(cyc_valid == 1'b0, 1, "cyc_valid in reset", {31'h0, cyc_valid}, 32'h0);
    chk(done == 1'b0, 1, "done in reset", {31'h0, done}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state after release
    chk(cyc_valid == 1'b0, 1, "cyc_valid after reset", {31'h0, cyc_valid}, 32'h0);
    chk(result == 8'h00, 1, "result after reset", {24'h0, result}, 32'h0);
    chk(flag_z == 1'b1 && flag_n == 1'b0, 1, "flags after reset",
        {30'h0, flag_z, flag_n}, 32'h2);

    // R3 no carry, R2 operand fetch across a page end
    run(2'd0, 0, 16'h0400, 16'h1234, 8'h10, 8'h00, 0, 0);
    run(2'd0, 0, 16'h04FF, 16'h00FF, 8'h00, 8'h00, 0, 0);
    // R4 carry cases
    run(2'd0, 0, 16'h0410, 16'hFEE8, 8'h80, 8'h00, 0, 0);
    run(2'd0, 1, 16'h0420, 16'h12FF, 8'h01, 8'h00, 0, 0);
    // R5 / R6 increment orderings, R7 wrap and sign, R11 poke while busy
    run(2'd1, 0, 16'h0430, 16'h3000, 8'h00, 8'h00, 0, 1);
    run(2'd1, 1, 16'h0440, 16'h3000, 8'h00, 8'h00, 0, 1);
    run(2'd1, 0, 16'h0450, 16'h2000, 8'h00, 8'h00, 0, 0);
    run(2'd1, 1, 16'h0460, 16'h2100, 8'h00, 8'h00, 0, 0);
    run(2'd1, 1, 16'h0470, 16'h2000, 8'h00, 8'h00, 0, 0);
    // R8 not taken, R9 same page, R10 crossing forward and backward
    run(2'd2, 0, 16'h0480, 16'h0000, 8'h00, 8'h10, 0, 1);
    run(2'd2, 0, 16'h0480, 16'h0000, 8'h00, 8'h10, 1, 0);
    run(2'd2, 0, 16'h04F0, 16'h0000, 8'h00, 8'h20, 1, 0);
    run(2'd2, 0, 16'h0500, 16'h0000, 8'h00, 8'hF0, 1, 0);

    // R12: reserved class is ignored
    @(negedge clk);
    op_class = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(cyc_valid == 1'b0, 12, "cyc_valid after reserved class", {31'h0, cyc_valid}, 32'h0);
      @(negedge clk);
    end
    chk(exp_q.size() == 0, 11, "scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule